// File: doc/BRIEF.md
# Dual-Output Interrupt Controller Register Bank

This block is the register and request core of a 64-source interrupt controller. Each source input is level sensitive: a change of level on a source line is copied into that source's pending bit, so a source raised and held sets its bit once, and software can still clear or set that bit through the force registers. Every source carries an enable bit, a type bit (normal or fast) and a 4-bit priority. The block drives a fast request and a normal request. The normal request is screened by a 5-bit threshold; the all-ones threshold switches screening off.

Software reaches the state through a 32-bit, word-addressed register port that completes in a single cycle. Writes take effect at the clock edge of the request. Read data is combinational from the current state. Both request outputs are registered. They follow the state one clock after it changes.

Top module: `irq_ctrl_bank`

## Requirements
- R1: When a source input changes level, its pending bit takes the new level at that clock edge. A level held steady does not change the pending bit again, so a force write that clears the bit while the input stays high leaves it at 0. Pending reads back at offset 18 (sources 63..32) and offset 19 (sources 31..0).
- R2: `fst_irq_o` is high one clock after the state holds at least one source that is pending, enabled and of fast type (type bit 1).
- R3: When the threshold equals 31, `nrm_irq_o` is high one clock after the state holds at least one source that is pending, enabled and of normal type (type bit 0).
- R4: When the threshold is below 31, `nrm_irq_o` is high one clock after the state holds a pending, enabled, normal source whose priority is strictly greater than the threshold. Priority 15 with threshold 15 gives no request.
- R5: A write to offset 2 sets the enable bit indexed by data bits [5:0]. A write to offset 3 clears that bit. All other data bits are ignored. Both offsets read as zero.
- R6: Enable is read and written at offsets 4 (sources 63..32) and 5 (sources 31..0). Type is read and written at offsets 6 (high) and 7 (low), with 1 meaning fast. Writing one half leaves the other half unchanged.
- R7: Priority word w is held at offset 15-w, so offsets 8..15 hold words 7..0. Source n takes bits [4*(n mod 8)+3 : 4*(n mod 8)] of word n/8. The words read back as written.
- R8: A write to offset 20 replaces pending bits 63..32 with the data, and a write to offset 21 replaces bits 31..0. Both offsets read as zero.
- R9: After reset, pending, enable, type, control and every priority word are zero, the threshold is 31, and both outputs are low.
- R10: Offset 0 (control) keeps only data bits [5:0], and its other bits read zero. Offset 1 (threshold) keeps only data bits [4:0].
- R11: Offsets 22/23 read pending AND enable AND normal type, high and low halves. Offsets 24/25 read the same with fast type. Writes to offsets 16..19 and 22..25 change nothing. Every offset not named in R5..R11 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level-sensitive interrupt source lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write strobe (1 write, 0 read) |
| addr_i | input | 6 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from state |
| nrm_irq_o | output | 1 | Registered normal interrupt request |
| fst_irq_o | output | 1 | Registered fast interrupt request |

## Verification
The hardest situation to reach from the ports is a pending bit that disagrees with a source line held steady. It arises only when a force write lands after the line has settled, and it shows whether capture follows changes of level rather than the level itself. A directed sequence raises a line, clears its bit by force, drops the line and raises it again. The random phase mixes force writes with flips of single source lines. The threshold boundaries (priority equal to the threshold, priority 15 against threshold 15, threshold 31 with priority 0) are driven directly, and the random phase picks threshold values that favour 31 and the 0..15 range.

// File: rtl/icb_pkg.sv
package icb_pkg;
  localparam int OFS_CTRL      = 0;
  localparam int OFS_MASK      = 1;
  localparam int OFS_EN_NUM    = 2;
  localparam int OFS_DIS_NUM   = 3;
  localparam int OFS_EN_HI     = 4;
  localparam int OFS_EN_LO     = 5;
  localparam int OFS_TYP_HI    = 6;
  localparam int OFS_TYP_LO    = 7;
  localparam int OFS_PRIO_LO   = 8;
  localparam int OFS_PRIO_HI   = 15;
  localparam int OFS_SRC_HI    = 18;
  localparam int OFS_SRC_LO    = 19;
  localparam int OFS_FRC_HI    = 20;
  localparam int OFS_FRC_LO    = 21;
  localparam int OFS_NPND_HI   = 22;
  localparam int OFS_NPND_LO   = 23;
  localparam int OFS_FPND_HI   = 24;
  localparam int OFS_FPND_LO   = 25;
  localparam int CTRL_W        = 6;
endpackage

// File: rtl/icb_pending.sv
module icb_pending #(
  parameter int NUM_SRC = 64,
  parameter int HALF    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               frc_hi_i,
  input  logic               frc_lo_i,
  input  logic [HALF-1:0]    frc_data_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q, pend_q, pend_d;

  // capture level changes only; a held level leaves force results alone
  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_i[i] != src_q[i]) pend_d[i] = src_i[i];
    if (frc_hi_i) pend_d[NUM_SRC-1:HALF] = frc_data_i;
    if (frc_lo_i) pend_d[HALF-1:0]       = frc_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/icb_nrm_gate.sv
module icb_nrm_gate #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5
) (
  input  logic [NUM_SRC-1:0]             flags_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [MASK_W-1:0]              mask_i,
  output logic                           hit_o
);
  logic [NUM_SRC-1:0] above;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_cmp
    assign above[n] = flags_i[n] && (MASK_W'(prio_i[n]) > mask_i);
  end

  assign hit_o = (mask_i == '1) ? (|flags_i) : (|above);
endmodule

// File: rtl/icb_rd_mux.sv
module icb_rd_mux
  import icb_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int DATA_W     = 32,
  parameter int MASK_W     = 5,
  parameter int ADDR_W     = 6,
  parameter int PRIO_WORDS = 8
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [CTRL_W-1:0]                 ctrl_i,
  input  logic [MASK_W-1:0]                 mask_i,
  input  logic [NUM_SRC-1:0]                en_i,
  input  logic [NUM_SRC-1:0]                typ_i,
  input  logic [NUM_SRC-1:0]                pend_i,
  input  logic [PRIO_WORDS-1:0][DATA_W-1:0] prio_i,
  output logic [DATA_W-1:0]                 rdata_o
);
  localparam int HALF = NUM_SRC / 2;

  logic [NUM_SRC-1:0] npnd, fpnd;
  assign npnd = pend_i & en_i & ~typ_i;
  assign fpnd = pend_i & en_i & typ_i;

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      OFS_CTRL:    rdata_o = DATA_W'(ctrl_i);
      OFS_MASK:    rdata_o = DATA_W'(mask_i);
      OFS_EN_HI:   rdata_o = en_i[NUM_SRC-1:HALF];
      OFS_EN_LO:   rdata_o = en_i[HALF-1:0];
      OFS_TYP_HI:  rdata_o = typ_i[NUM_SRC-1:HALF];
      OFS_TYP_LO:  rdata_o = typ_i[HALF-1:0];
      OFS_SRC_HI:  rdata_o = pend_i[NUM_SRC-1:HALF];
      OFS_SRC_LO:  rdata_o = pend_i[HALF-1:0];
      OFS_NPND_HI: rdata_o = npnd[NUM_SRC-1:HALF];
      OFS_NPND_LO: rdata_o = npnd[HALF-1:0];
      OFS_FPND_HI: rdata_o = fpnd[NUM_SRC-1:HALF];
      OFS_FPND_LO: rdata_o = fpnd[HALF-1:0];
      default: begin
        // priority words sit in reverse order
        for (int w = 0; w < PRIO_WORDS; w++)
          if (int'(addr_i) == OFS_PRIO_HI - w) rdata_o = prio_i[w];
      end
    endcase
  end
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank
  import icb_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5,
  parameter int ADDR_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               nrm_irq_o,
  output logic               fst_irq_o
);
  localparam int HALF       = NUM_SRC / 2;
  localparam int PER_WORD   = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = NUM_SRC / PER_WORD;
  localparam int IDX_W      = $clog2(NUM_SRC);

  logic                                wr;
  logic [CTRL_W-1:0]                   ctrl_q;
  logic [MASK_W-1:0]                   mask_q;
  logic [NUM_SRC-1:0]                  en_q, typ_q, pend_q;
  logic [PRIO_WORDS-1:0][DATA_W-1:0]   prio_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0]      src_prio;
  logic                                nrm_hit, nrm_q, fst_q;

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
      typ_q  <= '0;
      prio_q <= '0;
    end else if (wr) begin
      case (int'(addr_i))
        OFS_CTRL:    ctrl_q <= wdata_i[CTRL_W-1:0];
        OFS_MASK:    mask_q <= wdata_i[MASK_W-1:0];
        OFS_EN_NUM:  en_q[wdata_i[IDX_W-1:0]] <= 1'b1;
        OFS_DIS_NUM: en_q[wdata_i[IDX_W-1:0]] <= 1'b0;
        OFS_EN_HI:   en_q[NUM_SRC-1:HALF] <= wdata_i;
        OFS_EN_LO:   en_q[HALF-1:0]       <= wdata_i;
        OFS_TYP_HI:  typ_q[NUM_SRC-1:HALF] <= wdata_i;
        OFS_TYP_LO:  typ_q[HALF-1:0]       <= wdata_i;
        default: begin
          for (int w = 0; w < PRIO_WORDS; w++)
            if (int'(addr_i) == OFS_PRIO_HI - w) prio_q[w] <= wdata_i;
        end
      endcase
    end
  end

  icb_pending #(.NUM_SRC(NUM_SRC), .HALF(HALF)) i_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .frc_hi_i   (wr && int'(addr_i) == OFS_FRC_HI),
    .frc_lo_i   (wr && int'(addr_i) == OFS_FRC_LO),
    .frc_data_i (wdata_i),
    .pend_o     (pend_q)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_prio
    assign src_prio[n] = prio_q[n / PER_WORD][PRIO_W*(n % PER_WORD) +: PRIO_W];
  end

  icb_nrm_gate #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) i_nrm_gate (
    .flags_i (pend_q & en_q & ~typ_q),
    .prio_i  (src_prio),
    .mask_i  (mask_q),
    .hit_o   (nrm_hit)
  );

  icb_rd_mux #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .MASK_W(MASK_W),
    .ADDR_W(ADDR_W), .PRIO_WORDS(PRIO_WORDS)
  ) i_rd_mux (
    .addr_i  (addr_i),
    .ctrl_i  (ctrl_q),
    .mask_i  (mask_q),
    .en_i    (en_q),
    .typ_i   (typ_q),
    .pend_i  (pend_q),
    .prio_i  (prio_q),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nrm_q <= 1'b0;
      fst_q <= 1'b0;
    end else begin
      nrm_q <= nrm_hit;
      fst_q <= |(pend_q & en_q & typ_q);
    end
  end

  assign nrm_irq_o = nrm_q;
  assign fst_irq_o = fst_q;
endmodule

// File: rtl/icb_checker.sv
module icb_checker #(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5,
  parameter int ADDR_W  = 6
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_SRC-1:0]             src_i,
  input logic                           req_i,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [DATA_W-1:0]              wdata_i,
  input logic [DATA_W-1:0]              rdata_o,
  input logic [NUM_SRC-1:0]             pend_i,
  input logic [NUM_SRC-1:0]             en_i,
  input logic [NUM_SRC-1:0]             typ_i,
  input logic [MASK_W-1:0]              mask_i,
  input logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input logic                           nrm_i,
  input logic                           fst_i
);
  logic [NUM_SRC-1:0] nflags, fflags;
  logic               any_above;
  logic               frc_lo_wr;

  assign nflags    = pend_i & en_i & ~typ_i;
  assign fflags    = pend_i & en_i & typ_i;
  assign frc_lo_wr = req_i && we_i && (addr_i == ADDR_W'(21));

  always_comb begin
    any_above = 1'b0;
    for (int n = 0; n < NUM_SRC; n++)
      if (nflags[n] && ({1'b0, prio_i[n]} > mask_i)) any_above = 1'b1;
  end

  p_src_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(src_i[0]) && !frc_lo_wr) |=> pend_i[0]);

  p_fast_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fflags) |=> fst_i);

  p_fast_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fflags) |=> !fst_i);

  p_mask_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '1) |=> (nrm_i == $past(|nflags)));

  p_mask_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_i != '1) && !any_above) |=> !nrm_i);

  p_num_read_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i == ADDR_W'(2)) || (addr_i == ADDR_W'(3))) |-> (rdata_o == '0));

  p_force_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_lo_wr |=> (pend_i[DATA_W-1:0] == $past(wdata_i)));
endmodule

bind irq_ctrl_bank icb_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W),
  .MASK_W(MASK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pend_i  (pend_q),
  .en_i    (en_q),
  .typ_i   (typ_q),
  .mask_i  (mask_q),
  .prio_i  (src_prio),
  .nrm_i   (nrm_irq_o),
  .fst_i   (fst_irq_o)
);

// File: tb/test_irq_ctrl_bank.sv
module test_irq_ctrl_bank;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nrm, fst;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_pend = '0, m_en = '0, m_typ = '0;
  logic [31:0] m_pw [8];
  logic [4:0]  m_mask = 5'h1f;
  logic [31:0] m_ctrl = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_ctrl_bank i_irq_ctrl_bank (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .nrm_irq_o(nrm), .fst_irq_o(fst)
  );

  function automatic logic [3:0] m_prio(int n);
    return m_pw[n/8][4*(n%8) +: 4];
  endfunction

  function automatic logic exp_fast();
    return |(m_pend & m_en & m_typ);
  endfunction

  function automatic logic exp_nrm();
    logic [63:0] f = m_pend & m_en & ~m_typ;
    if (m_mask == 5'h1f) return |f;
    for (int n = 0; n < 64; n++)
      if (f[n] && ({1'b0, m_prio(n)} > m_mask)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mread(int a);
    logic [63:0] np = m_pend & m_en & ~m_typ;
    logic [63:0] fp = m_pend & m_en & m_typ;
    case (a)
      0: return m_ctrl;
      1: return {27'd0, m_mask};
      4: return m_en[63:32];
      5: return m_en[31:0];
      6: return m_typ[63:32];
      7: return m_typ[31:0];
      18: return m_pend[63:32];
      19: return m_pend[31:0];
      22: return np[63:32];
      23: return np[31:0];
      24: return fp[63:32];
      25: return fp[31:0];
      default: if (a >= 8 && a <= 15) return m_pw[15-a]; else return 32'd0;
    endcase
  endfunction

  task automatic model_write(int a, logic [31:0] d);
    case (a)
      0: m_ctrl = d & 32'h3f;
      1: m_mask = d[4:0];
      2: m_en[d[5:0]] = 1'b1;
      3: m_en[d[5:0]] = 1'b0;
      4: m_en[63:32] = d;
      5: m_en[31:0] = d;
      6: m_typ[63:32] = d;
      7: m_typ[31:0] = d;
      20: m_pend[63:32] = d;
      21: m_pend[31:0] = d;
      default: if (a >= 8 && a <= 15) m_pw[15-a] = d;
    endcase
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 6'(a); wdata = d;
    model_write(a, d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic set_src(logic [63:0] v);
    @(negedge clk);
    for (int i = 0; i < 64; i++)
      if (v[i] != src[i]) m_pend[i] = v[i];
    src = v;
    @(negedge clk);
  endtask

  task automatic rd(int a, string tag);
    req = 1'b1; we = 1'b0; addr = 6'(a);
    #1;
    chk($sformatf("%s rd@%0d", tag, a), rdata, mread(a));
    req = 1'b0;
  endtask

  task automatic chk_out(string tag);
    @(negedge clk);
    chk({tag, " R2 fast"}, {31'd0, fst}, {31'd0, exp_fast()});
    chk({tag, (m_mask == 5'h1f) ? " R3 nrm" : " R4 nrm"}, {31'd0, nrm}, {31'd0, exp_nrm()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int op;
    logic [31:0] r;
    for (int w = 0; w < 8; w++) m_pw[w] = '0;
    void'($urandom(32'h51c3));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 reset state
    for (int a = 0; a < 64; a++) rd(a, "R9 reset");
    chk("R9 reset fast", {31'd0, fst}, 32'd0);
    chk("R9 reset nrm", {31'd0, nrm}, 32'd0);
    chk("R9 reset mask", mread(1), 32'h1f);

    // R10 control and threshold bit keep
    wr(0, 32'hffff_ffff); rd(0, "R10 ctrl");
    chk("R10 ctrl value", rdata, 32'h0000_003f);
    wr(1, 32'h0000_00ff); rd(1, "R10 mask");
    wr(0, 32'h0); wr(1, 32'h1f);

    // R6 halves
    wr(5, 32'hffff_ffff); wr(4, 32'h0000_0001);
    rd(5, "R6 en lo"); rd(4, "R6 en hi");
    wr(4, 32'h0000_0002); rd(5, "R6 en lo kept");
    chk("R6 en lo value", rdata, 32'hffff_ffff);
    wr(7, 32'h0000_00f0); wr(6, 32'h8000_0000); rd(7, "R6 typ lo"); rd(6, "R6 typ hi");
    wr(5, 32'h0); wr(4, 32'h0); wr(7, 32'h0); wr(6, 32'h0);

    // R5 by-number with upper data bits set
    wr(2, 32'hffff_ffc7); rd(5, "R5 en num");
    chk("R5 en bit7", rdata, 32'h0000_0080);
    rd(2, "R5 read zero"); rd(3, "R5 read zero");
    wr(2, 32'h0000_003f); rd(4, "R5 en 63");
    wr(3, 32'h0000_0047); rd(5, "R5 dis num");
    chk("R5 dis bit7", rdata, 32'h0);

    // R7 priority layout: source 1 priority 5 in word 0 at offset 15
    wr(15, 32'h0000_0050); rd(15, "R7 prio w0");
    wr(8, 32'hf000_0000); rd(8, "R7 prio w7");

    // R1 held high vs force
    wr(2, 32'd1);
    set_src(64'h1); rd(19, "R1 rise"); chk("R1 rise bit", rdata, 32'h1);
    chk_out("R1");
    wr(21, 32'h0); rd(19, "R8 force clr");
    chk("R1 held stays clear", rdata, 32'h0);
    chk_out("R1 held");
    set_src(64'h0); rd(19, "R1 fall");
    set_src(64'h1); rd(19, "R1 re-rise"); chk("R1 re-rise bit", rdata, 32'h1);
    rd(20, "R8 read zero"); rd(21, "R8 read zero");

    // R4 threshold corners, source 1 prio 5, source 63 prio 15
    wr(3, 32'd0); wr(2, 32'd1); wr(21, 32'h2); chk_out("R3 mask31");
    chk("R3 nrm prio5 mask31", {31'd0, nrm}, 32'd1);
    wr(1, 32'd0); chk_out("R4 mask0");
    wr(1, 32'd5); chk_out("R4 equal");
    chk("R4 prio equal mask", {31'd0, nrm}, 32'd0);
    wr(1, 32'd4); chk_out("R4 below");
    chk("R4 prio above mask", {31'd0, nrm}, 32'd1);
    wr(21, 32'h0); wr(2, 32'd63); wr(20, 32'h8000_0000);
    wr(1, 32'd15); chk_out("R4 p15 m15");
    chk("R4 prio15 mask15", {31'd0, nrm}, 32'd0);
    wr(1, 32'd14); chk_out("R4 p15 m14");
    wr(1, 32'h1f); wr(15, 32'h0); wr(21, 32'h1); chk_out("R3 prio0");

    // R2 fast type
    wr(6, 32'h8000_0000); chk_out("R2 fast");
    chk("R2 fast set", {31'd0, fst}, 32'd1);
    rd(24, "R11 fpnd hi"); rd(22, "R11 npnd hi"); rd(23, "R11 npnd lo");

    // R11 writes to status offsets are ignored
    wr(19, 32'hffff_ffff); wr(18, 32'h0); wr(22, 32'h1234_5678); wr(16, 32'h0);
    rd(19, "R11 ignored"); rd(18, "R11 ignored"); chk_out("R11");

    // random mix
    for (int it = 0; it < 600; it++) begin
      op = $urandom_range(0, 9);
      case (op)
        0: wr($urandom_range(4, 5), $urandom());
        1: wr($urandom_range(6, 7), $urandom() & $urandom());
        2: wr($urandom_range(8, 15), $urandom());
        3: wr(1, ($urandom_range(0, 2) == 0) ? 32'h1f : 32'($urandom_range(0, 20)));
        4: wr(2, $urandom());
        5: wr(3, $urandom());
        6: set_src(src ^ (64'h1 << $urandom_range(0, 63)));
        7: wr($urandom_range(20, 21), $urandom());
        8: begin
             r = $urandom();
             wr(($urandom_range(0, 1) == 0) ? $urandom_range(16, 19) : $urandom_range(22, 25), r);
           end
        default: set_src({$urandom(), $urandom()});
      endcase
      chk_out($sformatf("rand%0d", it));
      rd($urandom_range(0, 63), "R11 rand");
      rd($urandom_range(18, 19), "R1 rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule